// File: doc/BRIEF.md
# DMA Destination Region Router

This block takes a stream of DMA transfers aimed at the graphics memory aperture and sends each one to a single sink. The sinks are a tile-accelerator input, a YUV converter input, a VRAM path with 64-bit bank interleaving, and a VRAM path with a flat 32-bit layout. A transfer opens with a command that carries a destination address and a byte count. The command can also be flagged as a single burst. After the command, 32-bit data beats arrive on the input one at a time and leave on the chosen sink with a registered valid strobe.

Four destination address bits (28, 25, 24 and 23) form a sparse key. The key selects the sink, and the remaining address bits only give the offset into RAM. There are two texture windows, and each has its own configuration input. That input decides whether the window writes the interleaved path or the linear path. The block samples it when a transfer is accepted, so changing it during a transfer has no effect. Transfers to either VRAM path are clipped at the end of RAM. Beats past that point are consumed from the input and dropped.

Top module: `dma_dest_router`

## Requirements
- R1: After reset, `sink_vld`, `busy` and `err` are all zero.
- R2: Keys 0x10000000 and 0x12000000 (address ANDed with 0x13800000) send every beat to the tile-accelerator sink (`sink_vld` bit 0) with `out_addr` zero, whatever the other address bits are. No clipping applies.
- R3: Keys 0x10800000 and 0x12800000 send every beat to the YUV sink (`sink_vld` bit 1) with `out_addr` zero.
- R4: Keys 0x11000000 and 0x11800000 form window 1. When `rgn1_sel` is zero, the beats go to the interleaved sink (`sink_vld` bit 2). For a running RAM offset `a`, the output address is `(a[2] ? RAM/2 : 0) + 4*(a>>3) + a[1:0]`.
- R5: Keys 0x13000000 and 0x13800000 form window 2, and `rgn2_sel` controls it in the same way.
- R6: When a window's select value is nonzero, the beats go to the linear sink (`sink_vld` bit 3). The output address is the destination address masked to the RAM size, and it rises by 4 on each beat.
- R7: On either VRAM path, the byte count is reduced to RAM size minus the masked offset whenever it would run past the end of RAM. Input beats beyond that point are consumed without any output.
- R8: When `start_burst` is set, the transfer is exactly 32 bytes (8 beats), and `start_len` is ignored.
- R9: If address bit 28 is clear, the key matches no sink. `err` pulses for one cycle after acceptance, and the transfer's beats are consumed with no output.
- R10: The window select inputs are sampled when a command is accepted. Changing them during a transfer does not change its path.
- R11: Data beats while idle, and commands while busy, are ignored.
- R12: A command with a zero byte count leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rgn1_sel | input | RGN_W | Window 1 path select: zero is interleaved, nonzero is linear |
| rgn2_sel | input | RGN_W | Window 2 path select |
| start_valid | input | 1 | Command strobe, accepted when not busy |
| start_burst | input | 1 | Command is a single 32-byte burst |
| start_addr | input | ADDR_W | Destination address |
| start_len | input | LEN_W | Byte count, a multiple of 4 |
| in_valid | input | 1 | Data beat strobe |
| in_data | input | DATA_W | Data beat |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | One-cycle pulse for an unmapped destination |
| sink_vld | output | 4 | One-hot sink strobe: bit 0 tile accelerator, bit 1 YUV, bit 2 interleaved, bit 3 linear |
| out_addr | output | RAM_AW | Sink address |
| out_data | output | DATA_W | Sink data |

## Verification
The bench builds the router with RAM_AW set to 12, which gives a 4 KB RAM. At that size a transfer of a few beats starting near offset 0xFF0 already crosses the end of RAM, so the clipping boundary in R7 can be reached with short transfers. The interleaved address split is also exercised across both banks within a small range. LEN_W is 16 and DATA_W is 32, and the high address bits above RAM_AW show that key decoding and offset masking are independent of each other.

// File: rtl/dmarte_pkg.sv
package dmarte_pkg;

   typedef enum logic [2:0] {
      RT_NONE = 3'd0,
      RT_TA   = 3'd1,
      RT_YUV  = 3'd2,
      RT_WIN1 = 3'd3,
      RT_WIN2 = 3'd4
   } route_e;

   // k = {addr[28], addr[25], addr[24], addr[23]}
   function automatic route_e key_route(input logic [3:0] k);
      if (!k[3])     return RT_NONE;
      else if (!k[1]) return k[0] ? RT_YUV : RT_TA;
      else            return k[2] ? RT_WIN2 : RT_WIN1;
   endfunction

endpackage

// File: rtl/dmarte_decode.sv
module dmarte_decode
   import dmarte_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output route_e            route,
   output logic              unmapped
);
   initial begin
      assert (ADDR_W >= 29) else $error("dmarte_decode: ADDR_W must cover bit 28");
   end

   always_comb begin
      route    = key_route({addr[28], addr[25], addr[24], addr[23]});
      unmapped = (route == RT_NONE);
   end
endmodule

// File: rtl/dmarte_clip.sv
module dmarte_clip #(
   parameter int RAM_AW  = 23,
   parameter int LEN_W   = 24,
   parameter int BEAT_SH = 2,
   localparam int BW     = LEN_W - BEAT_SH,
   localparam int CW     = (LEN_W > RAM_AW + 1) ? LEN_W : RAM_AW + 1
) (
   input  logic [RAM_AW-1:0] off,
   input  logic [LEN_W-1:0]  len,
   input  logic              clip_en,
   output logic [BW-1:0]     keep_beats,
   output logic [BW-1:0]     total_beats
);
   logic [CW-1:0] room, need, kept;

   always_comb begin
      room        = (CW'(1) << RAM_AW) - CW'(off);
      need        = CW'(len);
      kept        = (clip_en && (need > room)) ? room : need;
      keep_beats  = BW'(kept >> BEAT_SH);
      total_beats = len[LEN_W-1:BEAT_SH];
   end

   // R7: clipping never keeps more beats than the transfer carries
   always_comb begin
      a_keep_le_total_r7: assert (keep_beats <= total_beats);
   end
endmodule

// File: rtl/dmarte_xlate.sv
module dmarte_xlate #(
   parameter int RAM_AW = 23
) (
   input  logic [RAM_AW-1:0] off,
   output logic [RAM_AW-1:0] phys
);
   initial begin
      assert (RAM_AW >= 4) else $error("dmarte_xlate: RAM_AW too small to interleave");
   end

   // bit 2 picks the 32-bit bank, which lands in the top half of RAM
   assign phys = {off[2], off[RAM_AW-1:3], off[1:0]};
endmodule

// File: rtl/dma_dest_router.sv
module dma_dest_router
   import dmarte_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 24,
   parameter int RAM_AW = 23,
   parameter int RGN_W  = 32,
   localparam int BEAT_SH = $clog2(DATA_W / 8),
   localparam int BW      = LEN_W - BEAT_SH,
   localparam int BURST_B = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RGN_W-1:0]  rgn1_sel,
   input  logic [RGN_W-1:0]  rgn2_sel,
   input  logic              start_valid,
   input  logic              start_burst,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  start_len,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              busy,
   output logic              err,
   output logic [3:0]        sink_vld,
   output logic [RAM_AW-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   initial begin
      assert (DATA_W == 32) else $error("dma_dest_router: beats are 32-bit words");
      assert (LEN_W > $clog2(BURST_B)) else $error("dma_dest_router: LEN_W cannot hold a burst");
      assert (RAM_AW < 23 + 1) else $error("dma_dest_router: RAM_AW overlaps key bits");
   end

   route_e            route_d, route_q;
   logic              unmapped_d;
   logic [LEN_W-1:0]  len_eff;
   logic [RAM_AW-1:0] off_d, off_q, phys;
   logic [BW-1:0]     keep_d, total_d, keep_q, left_q;
   logic              lin_d, lin_q, busy_q, err_q, accept, beat;
   logic [3:0]        vld_q;
   logic [RAM_AW-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign len_eff = start_burst ? LEN_W'(BURST_B) : start_len;
   assign off_d   = start_addr[RAM_AW-1:0];
   assign accept  = start_valid && !busy_q;
   assign beat    = busy_q && in_valid;

   dmarte_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(start_addr), .route(route_d), .unmapped(unmapped_d));

   dmarte_clip #(.RAM_AW(RAM_AW), .LEN_W(LEN_W), .BEAT_SH(BEAT_SH)) u_clip (
      .off(off_d), .len(len_eff),
      .clip_en(route_d == RT_WIN1 || route_d == RT_WIN2),
      .keep_beats(keep_d), .total_beats(total_d));

   dmarte_xlate #(.RAM_AW(RAM_AW)) u_xl (.off(off_q), .phys(phys));

   always_comb begin
      unique case (route_d)
         RT_WIN1: lin_d = (rgn1_sel != '0);
         RT_WIN2: lin_d = (rgn2_sel != '0);
         default: lin_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         err_q   <= 1'b0;
         route_q <= RT_NONE;
         lin_q   <= 1'b0;
         off_q   <= '0;
         keep_q  <= '0;
         left_q  <= '0;
         vld_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         err_q <= accept && unmapped_d;
         vld_q <= '0;
         if (accept) begin
            route_q <= route_d;
            lin_q   <= lin_d;
            off_q   <= off_d;
            keep_q  <= unmapped_d ? '0 : keep_d;
            left_q  <= total_d;
            busy_q  <= (total_d != '0);
         end else if (beat) begin
            left_q <= left_q - 1'b1;
            if (left_q == BW'(1)) busy_q <= 1'b0;
            if (keep_q != '0) begin
               keep_q <= keep_q - 1'b1;
               off_q  <= off_q + RAM_AW'(4);
               data_q <= in_data;
               unique case (route_q)
                  RT_TA:   begin vld_q <= 4'b0001; addr_q <= '0; end
                  RT_YUV:  begin vld_q <= 4'b0010; addr_q <= '0; end
                  RT_WIN1, RT_WIN2: begin
                     vld_q  <= lin_q ? 4'b1000 : 4'b0100;
                     addr_q <= lin_q ? off_q : phys;
                  end
                  default: vld_q <= '0;
               endcase
            end
         end
      end
   end

   assign busy     = busy_q;
   assign err      = err_q;
   assign sink_vld = vld_q;
   assign out_addr = addr_q;
   assign out_data = data_q;

   // R6: at most one sink strobes per cycle
   p_onehot_sink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sink_vld));
   // R11: no beat reaches a sink one cycle after an idle cycle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> (sink_vld == 4'b0000));
   // R9: the error pulse never coincides with sink output
   p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (sink_vld == 4'b0000));
   // R2 R3: address-free sinks present a zero address
   p_stream_noaddr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sink_vld[0] || sink_vld[1]) |-> (out_addr == '0));
   // R10: the sampled path choice holds while a transfer runs
   p_path_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(lin_q));
   // R7: kept beats never exceed remaining beats
   p_clip_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (keep_q <= left_q));
endmodule

// File: tb/dma_dest_router_test.sv
module dma_dest_router_test;
   localparam int RAW = 12;
   localparam int RAM = 1 << RAW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [31:0] rgn1_sel = '0, rgn2_sel = '0;
   logic start_valid = 1'b0, start_burst = 1'b0, in_valid = 1'b0;
   logic [31:0] start_addr = '0, in_data = '0;
   logic [15:0] start_len = '0;
   logic busy, err;
   logic [3:0] sink_vld;
   logic [RAW-1:0] out_addr;
   logic [31:0] out_data;

   typedef struct {
      logic [3:0]     v;
      logic [RAW-1:0] a;
      logic [31:0]    d;
      string          tag;
   } item_t;

   item_t exp_q[$];
   int total = 0, bad = 0, seen = 0, serial = 0;

   always #10 clk = ~clk;

   dma_dest_router #(.ADDR_W(32), .DATA_W(32), .LEN_W(16), .RAM_AW(RAW), .RGN_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .rgn1_sel(rgn1_sel), .rgn2_sel(rgn2_sel),
      .start_valid(start_valid), .start_burst(start_burst), .start_addr(start_addr),
      .start_len(start_len), .in_valid(in_valid), .in_data(in_data),
      .busy(busy), .err(err), .sink_vld(sink_vld), .out_addr(out_addr), .out_data(out_data));

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per sink strobe
   always @(negedge clk) begin
      if (rst_n && sink_vld != 4'b0000) begin
         seen++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected beat", {28'd0, sink_vld, out_data}, 64'd0);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            chk(sink_vld == it.v && out_addr == it.a && out_data == it.d, it.tag,
                "sink/addr/data", {sink_vld, 16'(out_addr), out_data},
                {it.v, 16'(it.a), it.d});
         end
      end
   end

   task automatic xfer(input logic [31:0] a, input int len, input bit bst,
                       input int r1, input int r2, input bit flip, input bit poke,
                       input string tag);
      int L, off, keep, nb, sel;
      logic [3:0] v;
      bit unm, win, lin;
      L = bst ? 32 : len;
      off = int'(a) & (RAM - 1);
      unm = 1'b0; win = 1'b0; lin = 1'b0; v = 4'b0000;
      case (a & 32'h13800000)
         32'h10000000, 32'h12000000: v = 4'b0001;
         32'h10800000, 32'h12800000: v = 4'b0010;
         32'h11000000, 32'h11800000: begin win = 1'b1; lin = (r1 != 0); end
         32'h13000000, 32'h13800000: begin win = 1'b1; lin = (r2 != 0); end
         default: unm = 1'b1;
      endcase
      if (win) v = lin ? 4'b1000 : 4'b0100;
      keep = L;
      if (win && off + L > RAM) keep = RAM - off;
      if (unm) keep = 0;
      nb = L / 4;
      serial++;
      for (int i = 0; i < keep / 4; i++) begin
         item_t it;
         int ra;
         ra = off + 4 * i;
         it.v = v;
         it.d = 32'h5A000000 + (serial << 12) + i;
         if (!win) it.a = '0;
         else if (lin) it.a = RAW'(ra);
         else it.a = RAW'(((ra & 4) != 0 ? RAM / 2 : 0) + 4 * (ra >> 3) + (ra & 3));
         it.tag = tag;
         exp_q.push_back(it);
      end
      rgn1_sel = r1; rgn2_sel = r2;
      start_addr = a; start_len = 16'(len); start_burst = bst; start_valid = 1'b1;
      @(negedge clk);
      start_valid = 1'b0; start_burst = 1'b0;
      chk(err == unm, unm ? "R9" : tag, "err", {63'd0, err}, {63'd0, unm});
      chk(busy == (nb != 0), nb == 0 ? "R12" : tag, "busy", {63'd0, busy},
          {63'd0, (nb != 0)});
      sel = 0;
      for (int i = 0; i < nb; i++) begin
         if (i % 3 == 2) begin in_valid = 1'b0; @(negedge clk); end
         in_valid = 1'b1;
         in_data = 32'h5A000000 + (serial << 12) + i;
         if (poke && i == 1) begin
            start_addr = 32'h10000000; start_len = 16'd4; start_valid = 1'b1;
         end
         @(negedge clk);
         start_valid = 1'b0;
         if (flip && i == 0) begin
            rgn1_sel = (r1 != 0) ? 0 : 7; rgn2_sel = (r2 != 0) ? 0 : 7;
            sel = 1;
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, tag, "busy after end", {63'd0, busy}, 64'd0);
      chk(exp_q.size() == 0, tag, "pending beats", 64'(exp_q.size()), 64'd0);
      if (sel != 0) begin rgn1_sel = r1; rgn2_sel = r2; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int s0;
      repeat (3) @(negedge clk);
      chk(sink_vld == 0 && busy == 0 && err == 0, "R1", "reset outputs",
          {58'd0, sink_vld, busy, err}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sink_vld == 0 && busy == 0 && err == 0, "R1", "after release",
          {58'd0, sink_vld, busy, err}, 64'd0);

      xfer(32'h10000040, 16, 0, 0, 0, 0, 0, "R2");
      xfer(32'h12000FF0, 24, 0, 1, 1, 0, 0, "R2");          // no clip on stream
      xfer(32'h10800000, 8, 0, 0, 0, 0, 0, "R3");
      xfer(32'h12800100, 4, 1, 0, 0, 0, 0, "R8");           // burst to YUV
      xfer(32'h11000008, 24, 0, 0, 1, 0, 0, "R4");
      xfer(32'h11856004, 12, 0, 0, 1, 0, 0, "R4");          // alias, high bits ignored
      xfer(32'h13000010, 16, 0, 1, 0, 0, 0, "R5");
      xfer(32'h13800200, 16, 0, 0, 5, 0, 0, "R6");
      xfer(32'h11000300, 20, 0, 1, 0, 0, 0, "R6");
      xfer(32'h11000FF8, 24, 0, 3, 0, 0, 0, "R7");          // linear clip: 2 of 6
      xfer(32'h13000FF4, 16, 0, 0, 0, 0, 0, "R7");          // interleaved clip: 3 of 4
      xfer(32'h13800FFC, 4, 0, 0, 9, 0, 0, "R7");           // exactly at end: kept
      xfer(32'h13000040, 0, 1, 0, 2, 0, 0, "R8");           // burst linear
      xfer(32'h01000000, 8, 0, 0, 0, 0, 0, "R9");
      xfer(32'h03800000, 0, 1, 0, 0, 0, 0, "R9");
      xfer(32'h11000400, 16, 0, 0, 0, 1, 0, "R10");
      xfer(32'h13000500, 16, 0, 4, 4, 1, 0, "R10");
      xfer(32'h13800600, 16, 0, 4, 0, 0, 1, "R11");         // command while busy

      s0 = seen;
      for (int i = 0; i < 3; i++) begin
         in_valid = 1'b1; in_data = 32'hDEAD0000 + i; @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(seen == s0, "R11", "idle beats", 64'(seen), 64'(s0));

      xfer(32'h10000000, 0, 0, 0, 0, 0, 0, "R12");
      s0 = seen;
      in_valid = 1'b1; @(negedge clk); in_valid = 1'b0; @(negedge clk);
      chk(seen == s0 && busy == 0, "R12", "zero length idle",
          {31'd0, busy, 32'(seen)}, 64'(s0));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule